// File: doc/BRIEF.md
# Compressed Instruction Class Decoder

This block turns one 16-bit compressed instruction word into a flat set of decode fields that an execute stage can consume without looking at the raw opcode again. The operation class comes from one lookup indexed by the upper ten opcode bits (bits 15:6). A separate extractor then pulls out register indices, a scaled or sign-extended immediate, an ALU sub-operation and a branch condition, according to that class.

Encodings that belong to no class raise an illegal flag, and every other field is then zero. A parameter selects whether the decoded record leaves through a register stage, which adds one cycle of latency, or straight from the combinational logic. Executing the instruction, reaching memory and writing registers are left to other blocks.

Register fields are four bits wide so that the high-register forms and the implied stack pointer (13) and program counter (15) fit. The auxiliary register port carries the base register for memory forms and the second operand register for register add/subtract.

Top module: `cdec_top`

## Requirements
- R1: The class code is a function of opcode bits 15:6 only. The codes are: 0 illegal, 1 shift-imm, 2 add/sub-reg, 3 add/sub-imm3, 4 imm8-alu, 5 alu-reg, 6 high-reg, 7 branch-exchange, 8 pc-load, 9 reg-offset memory, 10 word-imm memory, 11 byte-imm memory, 12 half-imm memory, 13 sp memory, 14 address-gen, 15 sp-adjust, 16 push, 17 pop, 18 breakpoint, 19 multiple memory, 20 cond-branch, 21 software interrupt, 22 branch, 23 long-branch high half, 24 long-branch low half. Any field not named for a class is zero.
- R2: Bits 15:13 = 000 with bits 12:11 other than 11 give class 1: dst = bits 2:0, src = bits 5:3, imm = bits 10:6, subop = bits 12:11 (0 left, 1 logical right, 2 arithmetic right).
- R3: Bits 15:11 = 00011 give class 2 when bit 10 = 0 (aux = bits 8:6) and class 3 when bit 10 = 1 (imm = bits 8:6). In both, dst = bits 2:0, src = bits 5:3 and subop = bit 9 (1 = subtract).
- R4: Bits 15:13 = 001 give class 4: dst = bits 10:8, imm = bits 7:0, subop = bits 12:11 (0 move, 1 compare, 2 add, 3 subtract).
- R5: Bits 15:10 = 010000 give class 5: dst = bits 2:0, src = bits 5:3, subop = bits 9:6.
- R6: Bits 15:10 = 010001 with bits 9:8 = 11 give class 7 with src = {bit 6, bits 5:3}, whatever bit 7 holds. Otherwise they give class 6 with dst = {bit 7, bits 2:0}, src = {bit 6, bits 5:3} and subop = bits 9:8.
- R7: Bits 15:11 = 01001 give class 8 (aux = 15). Bits 15:12 = 1001 give class 13 (aux = 13, subop = bit 11, where 1 means load). Bits 15:12 = 1010 give class 14 (aux = 13 when bit 11 = 1, else 15). All three take dst = bits 10:8 and imm = bits 7:0 times 4.
- R8: Bits 15:12 = 0101 give class 9 with dst = bits 2:0, aux = bits 5:3, src = bits 8:6 and subop = bits 11:9. Bits 15:13 = 011 give class 10 (bit 12 = 0, imm = bits 10:6 times 4) or class 11 (bit 12 = 1, imm = bits 10:6). Bits 15:12 = 1000 give class 12 with imm = bits 10:6 times 2. Classes 10 to 12 take dst = bits 2:0, aux = bits 5:3 and subop = bit 11.
- R9: In the group with bits 15:12 = 1011, the following classes apply and every other value of bits 11:8 is illegal. Bits 11:8 = 0000 give class 15 with dst = aux = 13, imm = bits 6:0 times 4 and subop = bit 7 (1 = subtract). Bits 11:8 = 010x give class 16, where imm[7:0] is the register list and imm[14] is bit 8. Bits 11:8 = 110x give class 17, where imm[7:0] is the register list and imm[15] is bit 8. Classes 16 and 17 take aux = 13. Bits 11:8 = 1110 give class 18 with imm = bits 7:0.
- R10: Bits 15:12 = 1100 give class 19: aux = bits 10:8, imm = bits 7:0 (the register list), subop = bit 11 (1 = load).
- R11: In the group with bits 15:12 = 1101, bits 11:8 = 1110 is illegal and 1111 gives class 21 with imm = bits 7:0. Every other value gives class 20 with cond = bits 11:8 and imm = bits 7:0 sign-extended, times 2.
- R12: Bits 15:11 = 11100 give class 22 with imm = bits 10:0 sign-extended, times 2. The value 11101 is illegal. The value 11110 gives class 23 with imm = bits 10:0 sign-extended, times 4096. The value 11111 gives class 24 with imm = bits 10:0 zero-extended, times 2.
- R13: When the class is 0, illegal_out is 1 and every other output is 0. illegal_out is 0 for every other class.
- R14: With the register stage on (default), the outputs show the decode of the opcode sampled at the previous rising edge. While rst is high at an edge, the outputs show the illegal record, and the opcode has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset |
| op_in | input | 16 | Instruction word to decode |
| cls_out | output | 5 | Operation class code |
| dst_out | output | 4 | Destination register index |
| src_out | output | 4 | Source / offset register index |
| aux_out | output | 4 | Base register or second operand register |
| imm_out | output | 32 | Scaled, zero- or sign-extended immediate |
| subop_out | output | 4 | Sub-operation selector within the class |
| cond_out | output | 4 | Branch condition |
| illegal_out | output | 1 | Encoding belongs to no class |

## Verification
A wrong lookup entry does not fail on its own: it misclassifies a block of 64 opcodes that share bits 15:6. That block's class and every field taken from it are wrong one cycle after the word is presented. Because the sweep covers all 65536 words, each entry is reached. An extractor slip, such as a wrong scale, a missing sign extension or a misplaced high-register bit, appears only in the affected field of its class. It shows up in the same cycle as the class itself. A fault in the output stage shows as a one-cycle skew between the presented word and its record, or as a record leaking out during reset.

// File: rtl/cdec_pkg.sv
package cdec_pkg;

    localparam int OP_W      = 16;
    localparam int KEY_LSB   = 6;
    localparam int KEY_W     = OP_W - KEY_LSB;
    localparam int LUT_DEPTH = 1 << KEY_W;
    localparam int FLD_W     = 13;
    localparam int RIDX_W    = 4;
    localparam int SUB_W     = 4;
    localparam int COND_W    = 4;
    localparam int IMM_W     = 32;
    localparam int CLS_W     = 5;

    localparam logic [RIDX_W-1:0] SP_IDX = 4'd13;
    localparam logic [RIDX_W-1:0] PC_IDX = 4'd15;

    typedef enum logic [CLS_W-1:0] {
        CLS_ILLEGAL    = 5'd0,
        CLS_SHIFT_IMM  = 5'd1,
        CLS_ADDSUB_REG = 5'd2,
        CLS_ADDSUB_IMM = 5'd3,
        CLS_IMM8_ALU   = 5'd4,
        CLS_ALU_REG    = 5'd5,
        CLS_HI_REG     = 5'd6,
        CLS_BR_EXCH    = 5'd7,
        CLS_LOAD_PC    = 5'd8,
        CLS_MEM_REG    = 5'd9,
        CLS_MEM_WORD   = 5'd10,
        CLS_MEM_BYTE   = 5'd11,
        CLS_MEM_HALF   = 5'd12,
        CLS_MEM_SP     = 5'd13,
        CLS_ADDR_GEN   = 5'd14,
        CLS_SP_ADJ     = 5'd15,
        CLS_PUSH       = 5'd16,
        CLS_POP        = 5'd17,
        CLS_BKPT       = 5'd18,
        CLS_MEM_MULTI  = 5'd19,
        CLS_COND_BR    = 5'd20,
        CLS_SWI        = 5'd21,
        CLS_BRANCH     = 5'd22,
        CLS_LONG_HI    = 5'd23,
        CLS_LONG_LO    = 5'd24
    } op_class_e;

    typedef struct packed {
        op_class_e         cls;
        logic [RIDX_W-1:0] dst;
        logic [RIDX_W-1:0] src;
        logic [RIDX_W-1:0] aux;
        logic [IMM_W-1:0]  imm;
        logic [SUB_W-1:0]  subop;
        logic [COND_W-1:0] cond;
        logic              illegal;
    } dec_rec_t;

    function automatic dec_rec_t illegal_rec();
        dec_rec_t r;
        r         = '0;
        r.cls     = CLS_ILLEGAL;
        r.illegal = 1'b1;
        return r;
    endfunction

    // zero-extend a raw field and scale by 2**sh
    function automatic logic [IMM_W-1:0] zx(input logic [15:0] raw, input int sh);
        return IMM_W'(raw) << sh;
    endfunction

    // sign-extend the low 'bits' bits of raw and scale by 2**sh
    function automatic logic [IMM_W-1:0] sx(input logic [15:0] raw, input int bits, input int sh);
        logic [IMM_W-1:0] v;
        v = IMM_W'(raw) << (IMM_W - bits);
        v = IMM_W'($signed(v) >>> (IMM_W - bits));
        return v << sh;
    endfunction

    function automatic logic [RIDX_W-1:0] lo_reg(input logic [2:0] f);
        return {1'b0, f};
    endfunction

    // class of every opcode sharing the given upper bits
    function automatic op_class_e class_of_key(input logic [KEY_W-1:0] k);
        logic [OP_W-1:0] o;
        op_class_e       r;
        o = {k, {KEY_LSB{1'b0}}};
        r = CLS_ILLEGAL;
        if (o[15:11] == 5'b00011)
            r = o[10] ? CLS_ADDSUB_IMM : CLS_ADDSUB_REG;
        else if (o[15:13] == 3'b000)
            r = CLS_SHIFT_IMM;
        else if (o[15:13] == 3'b001)
            r = CLS_IMM8_ALU;
        else if (o[15:10] == 6'b010000)
            r = CLS_ALU_REG;
        else if (o[15:10] == 6'b010001)
            r = (o[9:8] == 2'b11) ? CLS_BR_EXCH : CLS_HI_REG;
        else if (o[15:11] == 5'b01001)
            r = CLS_LOAD_PC;
        else if (o[15:12] == 4'b0101)
            r = CLS_MEM_REG;
        else if (o[15:13] == 3'b011)
            r = o[12] ? CLS_MEM_BYTE : CLS_MEM_WORD;
        else if (o[15:12] == 4'b1000)
            r = CLS_MEM_HALF;
        else if (o[15:12] == 4'b1001)
            r = CLS_MEM_SP;
        else if (o[15:12] == 4'b1010)
            r = CLS_ADDR_GEN;
        else if (o[15:12] == 4'b1011) begin
            case (o[11:8])
                4'b0000:          r = CLS_SP_ADJ;
                4'b0100, 4'b0101: r = CLS_PUSH;
                4'b1100, 4'b1101: r = CLS_POP;
                4'b1110:          r = CLS_BKPT;
                default:          r = CLS_ILLEGAL;
            endcase
        end
        else if (o[15:12] == 4'b1100)
            r = CLS_MEM_MULTI;
        else if (o[15:12] == 4'b1101) begin
            case (o[11:8])
                4'b1110: r = CLS_ILLEGAL;
                4'b1111: r = CLS_SWI;
                default: r = CLS_COND_BR;
            endcase
        end
        else begin
            case (o[12:11])
                2'b00:   r = CLS_BRANCH;
                2'b01:   r = CLS_ILLEGAL;
                2'b10:   r = CLS_LONG_HI;
                default: r = CLS_LONG_LO;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/cdec_class_lut.sv
module cdec_class_lut
    import cdec_pkg::*;
#(
    parameter int KW    = KEY_W,
    parameter int DEPTH = LUT_DEPTH
) (
    input  logic [KW-1:0] key,
    output op_class_e     cls
);
    op_class_e rom [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        assign rom[e] = class_of_key(KW'(e));
    end

    assign cls = rom[key];
endmodule

// File: rtl/cdec_field_xtract.sv
module cdec_field_xtract
    import cdec_pkg::*;
(
    input  logic [FLD_W-1:0] fld,
    input  op_class_e        cls,
    output dec_rec_t         rec
);
    always_comb begin
        rec     = '0;
        rec.cls = cls;
        unique case (cls)
            CLS_SHIFT_IMM: begin
                rec.dst   = lo_reg(fld[2:0]);
                rec.src   = lo_reg(fld[5:3]);
                rec.imm   = zx(16'(fld[10:6]), 0);
                rec.subop = SUB_W'(fld[12:11]);
            end
            CLS_ADDSUB_REG, CLS_ADDSUB_IMM: begin
                rec.dst   = lo_reg(fld[2:0]);
                rec.src   = lo_reg(fld[5:3]);
                rec.subop = SUB_W'(fld[9]);
                if (cls == CLS_ADDSUB_REG) rec.aux = lo_reg(fld[8:6]);
                else                       rec.imm = zx(16'(fld[8:6]), 0);
            end
            CLS_IMM8_ALU: begin
                rec.dst   = lo_reg(fld[10:8]);
                rec.imm   = zx(16'(fld[7:0]), 0);
                rec.subop = SUB_W'(fld[12:11]);
            end
            CLS_ALU_REG: begin
                rec.dst   = lo_reg(fld[2:0]);
                rec.src   = lo_reg(fld[5:3]);
                rec.subop = fld[9:6];
            end
            CLS_HI_REG: begin
                rec.dst   = {fld[7], fld[2:0]};
                rec.src   = {fld[6], fld[5:3]};
                rec.subop = SUB_W'(fld[9:8]);
            end
            CLS_BR_EXCH: begin
                rec.src = {fld[6], fld[5:3]};
            end
            CLS_LOAD_PC: begin
                rec.dst = lo_reg(fld[10:8]);
                rec.aux = PC_IDX;
                rec.imm = zx(16'(fld[7:0]), 2);
            end
            CLS_MEM_REG: begin
                rec.dst   = lo_reg(fld[2:0]);
                rec.aux   = lo_reg(fld[5:3]);
                rec.src   = lo_reg(fld[8:6]);
                rec.subop = SUB_W'(fld[11:9]);
            end
            CLS_MEM_WORD, CLS_MEM_BYTE, CLS_MEM_HALF: begin
                rec.dst   = lo_reg(fld[2:0]);
                rec.aux   = lo_reg(fld[5:3]);
                rec.subop = SUB_W'(fld[11]);
                if (cls == CLS_MEM_WORD)      rec.imm = zx(16'(fld[10:6]), 2);
                else if (cls == CLS_MEM_HALF) rec.imm = zx(16'(fld[10:6]), 1);
                else                          rec.imm = zx(16'(fld[10:6]), 0);
            end
            CLS_MEM_SP: begin
                rec.dst   = lo_reg(fld[10:8]);
                rec.aux   = SP_IDX;
                rec.imm   = zx(16'(fld[7:0]), 2);
                rec.subop = SUB_W'(fld[11]);
            end
            CLS_ADDR_GEN: begin
                rec.dst = lo_reg(fld[10:8]);
                rec.aux = fld[11] ? SP_IDX : PC_IDX;
                rec.imm = zx(16'(fld[7:0]), 2);
            end
            CLS_SP_ADJ: begin
                rec.dst   = SP_IDX;
                rec.aux   = SP_IDX;
                rec.imm   = zx(16'(fld[6:0]), 2);
                rec.subop = SUB_W'(fld[7]);
            end
            CLS_PUSH, CLS_POP: begin
                rec.aux      = SP_IDX;
                rec.imm[7:0] = fld[7:0];
                if (cls == CLS_PUSH) rec.imm[14] = fld[8];
                else                 rec.imm[15] = fld[8];
            end
            CLS_BKPT, CLS_SWI: begin
                rec.imm = zx(16'(fld[7:0]), 0);
            end
            CLS_MEM_MULTI: begin
                rec.aux   = lo_reg(fld[10:8]);
                rec.imm   = zx(16'(fld[7:0]), 0);
                rec.subop = SUB_W'(fld[11]);
            end
            CLS_COND_BR: begin
                rec.cond = fld[11:8];
                rec.imm  = sx(16'(fld[7:0]), 8, 1);
            end
            CLS_BRANCH:  rec.imm = sx(16'(fld[10:0]), 11, 1);
            CLS_LONG_HI: rec.imm = sx(16'(fld[10:0]), 11, 12);
            CLS_LONG_LO: rec.imm = zx(16'(fld[10:0]), 1);
            default:     rec = illegal_rec();
        endcase
    end
endmodule

// File: rtl/cdec_out_stage.sv
module cdec_out_stage
    import cdec_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  dec_rec_t d,
    output dec_rec_t q
);
    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) q <= illegal_rec();
            else     q <= d;
        end
    end else begin : g_comb
        assign q = d;
    end
endmodule

// File: rtl/cdec_top.sv
module cdec_top
    import cdec_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [OP_W-1:0]    op_in,
    output logic [CLS_W-1:0]   cls_out,
    output logic [RIDX_W-1:0]  dst_out,
    output logic [RIDX_W-1:0]  src_out,
    output logic [RIDX_W-1:0]  aux_out,
    output logic [IMM_W-1:0]   imm_out,
    output logic [SUB_W-1:0]   subop_out,
    output logic [COND_W-1:0]  cond_out,
    output logic               illegal_out
);
    op_class_e lut_cls;
    dec_rec_t  raw_rec;
    dec_rec_t  out_rec;

    cdec_class_lut u_lut (
        .key (op_in[OP_W-1:KEY_LSB]),
        .cls (lut_cls)
    );

    cdec_field_xtract u_fld (
        .fld (op_in[FLD_W-1:0]),
        .cls (lut_cls),
        .rec (raw_rec)
    );

    cdec_out_stage #(.OUT_REG(OUT_REG)) u_stage (
        .clk (clk),
        .rst (rst),
        .d   (raw_rec),
        .q   (out_rec)
    );

    assign cls_out     = out_rec.cls;
    assign dst_out     = out_rec.dst;
    assign src_out     = out_rec.src;
    assign aux_out     = out_rec.aux;
    assign imm_out     = out_rec.imm;
    assign subop_out   = out_rec.subop;
    assign cond_out    = out_rec.cond;
    assign illegal_out = out_rec.illegal;

    // R13
    illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_out |-> (cls_out == '0 && dst_out == '0 && src_out == '0 && aux_out == '0
                         && imm_out == '0 && subop_out == '0 && cond_out == '0));

    // R1
    class_zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (cls_out == CLS_ILLEGAL) |-> illegal_out);

    // R11
    cond_only_branch_chk: assert property (@(posedge clk) disable iff (rst)
        (cond_out != '0) |-> (cls_out == CLS_COND_BR));

    // R6
    high_dst_chk: assert property (@(posedge clk) disable iff (rst)
        dst_out[RIDX_W-1] |-> (cls_out == CLS_HI_REG || cls_out == CLS_SP_ADJ));

    // R12
    branch_even_chk: assert property (@(posedge clk) disable iff (rst)
        (cls_out == CLS_BRANCH || cls_out == CLS_COND_BR || cls_out == CLS_LONG_LO)
        |-> !imm_out[0]);

    // R9
    sp_adj_regs_chk: assert property (@(posedge clk) disable iff (rst)
        (cls_out == CLS_SP_ADJ) |-> (dst_out == SP_IDX && aux_out == SP_IDX && src_out == '0));

    if (OUT_REG) begin : g_lat_chk
        // R14
        hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $stable(op_in)) |=> ($stable(cls_out) && $stable(imm_out)));
    end
endmodule

// File: tb/cdec_top_test.sv
module cdec_top_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] op_in;
    logic [4:0]  cls_out;
    logic [3:0]  dst_out, src_out, aux_out, subop_out, cond_out;
    logic [31:0] imm_out;
    logic        illegal_out;

    always #10 clk = ~clk;

    cdec_top uut (
        .clk(clk), .rst(rst), .op_in(op_in),
        .cls_out(cls_out), .dst_out(dst_out), .src_out(src_out), .aux_out(aux_out),
        .imm_out(imm_out), .subop_out(subop_out), .cond_out(cond_out),
        .illegal_out(illegal_out)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // reference model built directly from the requirement text
    function automatic logic [57:0] ref_dec(input logic [15:0] o);
        logic [4:0] c; logic [3:0] d, s, a, sb, cd; logic [31:0] im; logic il;
        c = 0; d = 0; s = 0; a = 0; sb = 0; cd = 0; im = 0; il = 0;
        casez (o)
            16'b00011???????????: begin
                c = o[10] ? 5'd3 : 5'd2; d = {1'b0,o[2:0]}; s = {1'b0,o[5:3]}; sb = {3'b0,o[9]};
                if (o[10]) im = {29'b0,o[8:6]}; else a = {1'b0,o[8:6]};
            end
            16'b000?????????????: begin
                c = 1; d = {1'b0,o[2:0]}; s = {1'b0,o[5:3]}; im = {27'b0,o[10:6]}; sb = {2'b0,o[12:11]};
            end
            16'b001?????????????: begin
                c = 4; d = {1'b0,o[10:8]}; im = {24'b0,o[7:0]}; sb = {2'b0,o[12:11]};
            end
            16'b010000??????????: begin
                c = 5; d = {1'b0,o[2:0]}; s = {1'b0,o[5:3]}; sb = o[9:6];
            end
            16'b01000111????????: begin c = 7; s = {o[6],o[5:3]}; end
            16'b010001??????????: begin
                c = 6; d = {o[7],o[2:0]}; s = {o[6],o[5:3]}; sb = {2'b0,o[9:8]};
            end
            16'b01001???????????: begin c = 8; d = {1'b0,o[10:8]}; a = 15; im = {22'b0,o[7:0],2'b0}; end
            16'b0101????????????: begin
                c = 9; d = {1'b0,o[2:0]}; a = {1'b0,o[5:3]}; s = {1'b0,o[8:6]}; sb = {1'b0,o[11:9]};
            end
            16'b011?????????????: begin
                c = o[12] ? 5'd11 : 5'd10; d = {1'b0,o[2:0]}; a = {1'b0,o[5:3]}; sb = {3'b0,o[11]};
                im = o[12] ? {27'b0,o[10:6]} : {25'b0,o[10:6],2'b0};
            end
            16'b1000????????????: begin
                c = 12; d = {1'b0,o[2:0]}; a = {1'b0,o[5:3]}; sb = {3'b0,o[11]}; im = {26'b0,o[10:6],1'b0};
            end
            16'b1001????????????: begin
                c = 13; d = {1'b0,o[10:8]}; a = 13; im = {22'b0,o[7:0],2'b0}; sb = {3'b0,o[11]};
            end
            16'b1010????????????: begin
                c = 14; d = {1'b0,o[10:8]}; a = o[11] ? 4'd13 : 4'd15; im = {22'b0,o[7:0],2'b0};
            end
            16'b10110000????????: begin c = 15; d = 13; a = 13; im = {23'b0,o[6:0],2'b0}; sb = {3'b0,o[7]}; end
            16'b1011010?????????: begin c = 16; a = 13; im = {17'b0,o[8],6'b0,o[7:0]}; end
            16'b1011110?????????: begin c = 17; a = 13; im = {16'b0,o[8],7'b0,o[7:0]}; end
            16'b10111110????????: begin c = 18; im = {24'b0,o[7:0]}; end
            16'b1011????????????: begin c = 0; end
            16'b1100????????????: begin c = 19; a = {1'b0,o[10:8]}; im = {24'b0,o[7:0]}; sb = {3'b0,o[11]}; end
            16'b11011110????????: begin c = 0; end
            16'b11011111????????: begin c = 21; im = {24'b0,o[7:0]}; end
            16'b1101????????????: begin c = 20; cd = o[11:8]; im = {{23{o[7]}},o[7:0],1'b0}; end
            16'b11100???????????: begin c = 22; im = {{20{o[10]}},o[10:0],1'b0}; end
            16'b11110???????????: begin c = 23; im = {{9{o[10]}},o[10:0],12'b0}; end
            16'b11111???????????: begin c = 24; im = {20'b0,o[10:0],1'b0}; end
            default: c = 0;
        endcase
        il = (c == 0);
        return {c, d, s, a, im, sb, cd, il};
    endfunction

    function automatic string tag_of(input logic [4:0] c);
        case (c)
            5'd1:                    return "R2";
            5'd2, 5'd3:              return "R3";
            5'd4:                    return "R4";
            5'd5:                    return "R5";
            5'd6, 5'd7:              return "R6";
            5'd8, 5'd13, 5'd14:      return "R7";
            5'd9, 5'd10, 5'd11, 5'd12: return "R8";
            5'd15, 5'd16, 5'd17, 5'd18: return "R9";
            5'd19:                   return "R10";
            5'd20, 5'd21:            return "R11";
            5'd22, 5'd23, 5'd24:     return "R12";
            default:                 return "R13";
        endcase
    endfunction

    function automatic logic [57:0] actual();
        return {cls_out, dst_out, src_out, aux_out, imm_out, subop_out, cond_out, illegal_out};
    endfunction

    task automatic check_vec(input logic [57:0] exp, input string tag, input logic [15:0] o);
        logic [57:0] act;
        act = actual();
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s op=%h actual=%h expected=%h", tag, o, act, exp);
        end
    endtask

    task automatic apply_chk(input logic [15:0] o, input string tag);
        @(negedge clk) op_in = o;
        @(posedge clk);
        #2;
        check_vec(ref_dec(o), tag, o);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog R14 actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [57:0] ill_rec;
        ill_rec = 58'h1;
        rst   = 1'b1;
        op_in = 16'h0000;
        repeat (3) @(posedge clk);
        #2;
        check_vec(ill_rec, "R14", op_in);           // reset record
        @(negedge clk) op_in = 16'h2000;            // decodable word held in reset
        @(posedge clk);
        #2;
        check_vec(ill_rec, "R14", op_in);
        @(negedge clk) rst = 1'b0;

        // directed corners
        apply_chk(16'h0A4B, "R2");  apply_chk(16'h17FF, "R2");
        apply_chk(16'h1C0A, "R3");  apply_chk(16'h1A53, "R3");
        apply_chk(16'h38FF, "R4");  apply_chk(16'h2000, "R4");
        apply_chk(16'h4340, "R5");  apply_chk(16'h43FF, "R5");
        apply_chk(16'h46FF, "R6");  apply_chk(16'h4770, "R6");  apply_chk(16'h47F0, "R6");
        apply_chk(16'h4FFF, "R7");  apply_chk(16'hA8FF, "R7");
        apply_chk(16'hA000, "R7");  apply_chk(16'h9FFF, "R7");
        apply_chk(16'h6FFF, "R8");  apply_chk(16'h7FFF, "R8");
        apply_chk(16'h8FFF, "R8");  apply_chk(16'h5E3A, "R8");
        apply_chk(16'hB0FF, "R9");  apply_chk(16'hB07F, "R9");  apply_chk(16'hB5FF, "R9");
        apply_chk(16'hBDFF, "R9");  apply_chk(16'hBEAB, "R9");
        apply_chk(16'hB100, "R9");  apply_chk(16'hBF00, "R9");
        apply_chk(16'hCFFF, "R10"); apply_chk(16'hC100, "R10");
        apply_chk(16'hD080, "R11"); apply_chk(16'hDE00, "R11");
        apply_chk(16'hDF12, "R11"); apply_chk(16'hD97F, "R11");
        apply_chk(16'hE400, "R12"); apply_chk(16'hE800, "R12");
        apply_chk(16'hF7FF, "R12"); apply_chk(16'hFFFF, "R12");
        apply_chk(16'hE9A5, "R13");

        // one-cycle latency: new word is not visible before the next edge
        apply_chk(16'h2055, "R14");
        @(negedge clk) op_in = 16'hE800;
        #2;
        check_vec(ref_dec(16'h2055), "R14", 16'h2055);
        @(posedge clk);
        #2;
        check_vec(ref_dec(16'hE800), "R14", 16'hE800);

        // every opcode value
        for (int i = 0; i < 65536; i++) begin
            logic [15:0] o;
            o = i[15:0];
            apply_chk(o, tag_of(ref_dec(o)[57:53]));
        end

        // seeded random pass, biased toward the dense groups
        void'($urandom(32'h00C0DE17));
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] o;
            o = 16'($urandom);
            if (n % 3 == 1) o[15:12] = 4'b1011;
            if (n % 3 == 2) o[15:12] = 4'b1101;
            apply_chk(o, "R1");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule